// File: doc/BRIEF.md
# Descriptor Chain Source DMA

This block is the read side of a DMA engine that feeds a downstream consumer, such as a hash core, with a stream of 32-bit words. It runs in one of two ways. In single-buffer mode it reads one contiguous region, given by a start address and a byte count. In list mode it walks a chain of descriptors in memory. Each descriptor is four consecutive words: the data address, the byte count, the address of the following descriptor, and a flag word. When bit 31 of the flag word is set, that descriptor is the last one.

Software first writes the buffer, size or list-head registers, then writes the mode word with the enable bit set. While a transfer runs, the block reads memory one word at a time over a request/response port. Every data word goes out on a valid/ready stream with a count of its valid bytes. When the last source byte has been handed over, a one-cycle `src_done` pulse is raised. This can happen while the consumer is still working on that data. A memory error response ends the walk at once with an `rd_err` pulse instead.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset `busy`, `mem_req_valid`, `out_valid`, `src_done` and `rd_err` are all low.
- R2: A mode write (select 0) that is accepted with bit 31 set and bit 25 clear starts a single-buffer transfer. The transfer uses the buffer-address (select 1) and buffer-size (select 2) registers. Words are read at ascending addresses and are emitted in that order. `out_bytes` is 4 for every word except the last, which carries the remaining 1 to 4 bytes.
- R3: A mode write with bits 31 and 25 both set starts a list walk at the list-head register (select 3). Each descriptor is read as four words at base, base+4, base+8 and base+12, holding source address, byte count, next address and flags. The descriptor's data is then streamed as in R2.
- R4: When flag bit 31 is set, the walk ends after that descriptor's data and the next-address word is ignored. When it is clear, the walk continues at the next address, which need not be contiguous with the current descriptor.
- R5: A descriptor with a byte count of 0 produces no data reads and no output words. The walk moves on or ends according to its flag bit.
- R6: `src_done` pulses for exactly one cycle per completed transfer, and `busy` is low in that cycle. When the final descriptor or buffer has data, the pulse comes in the cycle after the final output word is accepted. A single-buffer transfer of size 0 ends with a pulse and no reads.
- R7: A memory response with `mem_rsp_err` set ends the transfer. `rd_err` pulses once, `src_done` does not pulse, and no further requests or output words are issued.
- R8: A mode write while `busy` is high is ignored. It starts nothing and does not change the request attributes.
- R9: `mem_req_attr` carries bits 30:28 of the mode word that started the transfer, on every request of that transfer.
- R10: `out_valid` with its data, and `mem_req_valid` with its address, are held stable until accepted. Under backpressure no word is lost or repeated.
- R11: A mode write with bit 31 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 buffer address, 2 buffer size, 3 list head |
| cfg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the word to read |
| mem_req_attr | output | 3 | Attribute bits from the mode word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Read response carries an error |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Output word |
| out_bytes | output | 3 | Valid bytes in the output word (1 to 4) |
| busy | output | 1 | A transfer is in progress |
| src_done | output | 1 | One-cycle pulse: all source data delivered |
| rd_err | output | 1 | One-cycle pulse: transfer aborted by a read error |

## Verification
The bench builds the block with its default 32-bit address and length widths. It pairs the block with a 256-word memory model, which keeps every descriptor and buffer within a 1 KB window. Single-buffer sizes are swept from 0 to 13 bytes, which reaches every partial-word ending and the empty case. Pseudo-random ready signals on both the memory and the output sides alternate with full-rate runs. The list cases cover a contiguous chain with an empty middle entry, a chain that jumps through non-adjacent addresses to an empty terminating entry, a terminating entry whose next address points at a real descriptor, and read errors injected on a data word and on a descriptor word.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
    localparam int WORD_W        = 32;
    localparam int WORD_BYTES    = WORD_W / 8;
    localparam int BYTE_SH       = $clog2(WORD_BYTES);
    localparam int NB_W          = BYTE_SH + 1;
    localparam int ATTR_W        = 3;
    localparam int MODE_EN_BIT   = 31;
    localparam int MODE_LIST_BIT = 25;
    localparam int MODE_ATTR_LSB = 28;
    localparam int DESC_LAST_BIT = 31;

    typedef enum logic [1:0] {
        CFG_MODE      = 2'd0,
        CFG_BUF_ADDR  = 2'd1,
        CFG_BUF_LEN   = 2'd2,
        CFG_LIST_HEAD = 2'd3
    } cfg_sel_e;

    // word order inside a descriptor; the walker decodes by this index
    typedef enum logic [1:0] {
        DW_SRC   = 2'd0,
        DW_LEN   = 2'd1,
        DW_NEXT  = 2'd2,
        DW_FLAGS = 2'd3
    } desc_word_e;

    typedef enum logic [2:0] {
        W_IDLE  = 3'd0,
        W_DREQ  = 3'd1,
        W_DWAIT = 3'd2,
        W_BREQ  = 3'd3,
        W_BWAIT = 3'd4,
        W_PUSH  = 3'd5
    } walk_state_e;
endpackage

// File: rtl/ldw_cfg_regs.sv
module ldw_cfg_regs
    import ldw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic                  busy,
    output logic                  start,
    output logic                  start_list,
    output logic [ADDR_W-1:0]     buf_addr,
    output logic [LEN_W-1:0]      buf_len,
    output logic [ADDR_W-1:0]     list_head,
    output logic [ATTR_W-1:0]     attr
);
    typedef struct packed {
        logic [ATTR_W-1:0] attr;
        logic [ADDR_W-1:0] buf_addr;
        logic [LEN_W-1:0]  buf_len;
        logic [ADDR_W-1:0] head;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        start = 1'b0;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_MODE: begin
                    // a running transfer owns the mode word
                    if (!busy) begin
                        cfg_d.attr = cfg_wdata[MODE_ATTR_LSB +: ATTR_W];
                        start      = cfg_wdata[MODE_EN_BIT];
                    end
                end
                CFG_BUF_ADDR:  cfg_d.buf_addr = cfg_wdata[ADDR_W-1:0];
                CFG_BUF_LEN:   cfg_d.buf_len  = cfg_wdata[LEN_W-1:0];
                CFG_LIST_HEAD: cfg_d.head     = cfg_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign start_list = cfg_wdata[MODE_LIST_BIT];
    assign buf_addr   = cfg_q.buf_addr;
    assign buf_len    = cfg_q.buf_len;
    assign list_head  = cfg_q.head;
    assign attr       = cfg_q.attr;
endmodule

// File: rtl/ldw_beat_calc.sv
module ldw_beat_calc
    import ldw_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0] rem,
    output logic [NB_W-1:0]  nbytes,
    output logic [LEN_W-1:0] rem_next,
    output logic             last_beat
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_BYTES);

    logic full;

    always_comb begin
        full      = (rem >= FULL_LEN);
        nbytes    = full ? NB_W'(WORD_BYTES) : NB_W'(rem);
        rem_next  = rem - LEN_W'(nbytes);
        last_beat = (rem_next == '0);
    end
endmodule

// File: rtl/ldw_walker.sv
module ldw_walker
    import ldw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_list,
    input  logic [ADDR_W-1:0]  buf_addr,
    input  logic [LEN_W-1:0]   buf_len,
    input  logic [ADDR_W-1:0]  list_head,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic [NB_W-1:0]    out_bytes,
    output logic               busy,
    output logic               src_done,
    output logic               rd_err
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        walk_state_e        st;
        logic [ADDR_W-1:0]  ptr;
        logic [1:0]         widx;
        logic [ADDR_W-1:0]  dsrc;
        logic [LEN_W-1:0]   dlen;
        logic [ADDR_W-1:0]  dnext;
        logic               last;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   rem;
        logic [WORD_W-1:0]  word;
        logic               done;
        logic               err;
    } walk_t;

    walk_t w_d, w_q;

    logic [NB_W-1:0]   beat_bytes;
    logic [LEN_W-1:0]  rem_after;
    logic              beat_is_last;
    logic [ADDR_W-1:0] desc_addr;

    ldw_beat_calc #(.LEN_W(LEN_W)) u_beat (
        .rem       (w_q.rem),
        .nbytes    (beat_bytes),
        .rem_next  (rem_after),
        .last_beat (beat_is_last)
    );

    assign desc_addr = w_q.ptr + (ADDR_W'(w_q.widx) << BYTE_SH);

    always_comb begin
        w_d           = w_q;
        w_d.done      = 1'b0;
        w_d.err       = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = w_q.addr;
        out_valid     = 1'b0;

        case (w_q.st)
            W_IDLE: begin
                if (start) begin
                    if (start_list) begin
                        w_d.ptr  = list_head;
                        w_d.widx = DW_SRC;
                        w_d.st   = W_DREQ;
                    end else begin
                        w_d.addr = buf_addr;
                        w_d.rem  = buf_len;
                        w_d.last = 1'b1;
                        if (buf_len == '0) w_d.done = 1'b1;
                        else               w_d.st   = W_BREQ;
                    end
                end
            end

            W_DREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_addr;
                if (mem_req_ready) w_d.st = W_DWAIT;
            end

            W_DWAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        w_d.err = 1'b1;
                        w_d.st  = W_IDLE;
                    end else begin
                        w_d.widx = w_q.widx + 2'd1;
                        w_d.st   = W_DREQ;
                        case (desc_word_e'(w_q.widx))
                            DW_SRC:  w_d.dsrc  = ADDR_W'(mem_rsp_data);
                            DW_LEN:  w_d.dlen  = LEN_W'(mem_rsp_data);
                            DW_NEXT: w_d.dnext = ADDR_W'(mem_rsp_data);
                            default: begin
                                // flag word completes the descriptor
                                w_d.last = mem_rsp_data[DESC_LAST_BIT];
                                w_d.addr = w_q.dsrc;
                                w_d.rem  = w_q.dlen;
                                if (w_q.dlen != '0) begin
                                    w_d.st = W_BREQ;
                                end else if (mem_rsp_data[DESC_LAST_BIT]) begin
                                    w_d.done = 1'b1;
                                    w_d.st   = W_IDLE;
                                end else begin
                                    w_d.ptr = w_q.dnext;
                                end
                            end
                        endcase
                    end
                end
            end

            W_BREQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) w_d.st = W_BWAIT;
            end

            W_BWAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        w_d.err = 1'b1;
                        w_d.st  = W_IDLE;
                    end else begin
                        w_d.word = mem_rsp_data;
                        w_d.st   = W_PUSH;
                    end
                end
            end

            W_PUSH: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    w_d.rem  = rem_after;
                    w_d.addr = w_q.addr + STEP;
                    if (!beat_is_last) begin
                        w_d.st = W_BREQ;
                    end else if (w_q.last) begin
                        w_d.done = 1'b1;
                        w_d.st   = W_IDLE;
                    end else begin
                        w_d.ptr  = w_q.dnext;
                        w_d.widx = DW_SRC;
                        w_d.st   = W_DREQ;
                    end
                end
            end

            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign out_data  = w_q.word;
    assign out_bytes = beat_bytes;
    assign busy      = (w_q.st != W_IDLE);
    assign src_done  = w_q.done;
    assign rd_err    = w_q.err;
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
    import ldw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [ATTR_W-1:0]   mem_req_attr,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data,
    output logic [NB_W-1:0]     out_bytes,
    output logic                busy,
    output logic                src_done,
    output logic                rd_err
);
    logic              start;
    logic              start_list;
    logic [ADDR_W-1:0] buf_addr;
    logic [LEN_W-1:0]  buf_len;
    logic [ADDR_W-1:0] list_head;

    ldw_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .start      (start),
        .start_list (start_list),
        .buf_addr   (buf_addr),
        .buf_len    (buf_len),
        .list_head  (list_head),
        .attr       (mem_req_attr)
    );

    ldw_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_list    (start_list),
        .buf_addr      (buf_addr),
        .buf_len       (buf_len),
        .list_head     (list_head),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_bytes     (out_bytes),
        .busy          (busy),
        .src_done      (src_done),
        .rd_err        (rd_err)
    );
endmodule

// File: rtl/ldw_chk.sv
module ldw_chk
    import ldw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [ATTR_W-1:0]  mem_req_attr,
    input logic               out_valid,
    input logic               out_ready,
    input logic [WORD_W-1:0]  out_data,
    input logic [NB_W-1:0]    out_bytes,
    input logic               busy,
    input logic               src_done,
    input logic               rd_err
);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_bytes));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !out_valid);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_done |-> !busy);

    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> !busy && !src_done);

    // R2
    bytes_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bytes != '0) && (out_bytes <= NB_W'(WORD_BYTES)));

    // R9
    attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mem_req_attr));
endmodule

bind desc_chain_dma ldw_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_attr  (mem_req_attr),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_bytes     (out_bytes),
    .busy          (busy),
    .src_done      (src_done),
    .rd_err        (rd_err)
);

// File: tb/desc_chain_dma_tb.sv
module desc_chain_dma_tb;
    import ldw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;
    localparam int CAP_MAX    = 128;
    localparam logic [31:0] EN_BIT   = 32'h8000_0000;
    localparam logic [31:0] LIST_BIT = 32'h0200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic [2:0]  mem_req_attr;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [31:0] mem_rsp_data;
    logic        out_valid, out_ready;
    logic [31:0] out_data;
    logic [2:0]  out_bytes;
    logic        busy, src_done, rd_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_chain_dma u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_attr(mem_req_attr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_bytes(out_bytes),
        .busy(busy), .src_done(src_done), .rd_err(rd_err)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [MEM_WORDS];
    logic [7:0]  lfsr;
    bit          bp_en = 1'b0;
    int          err_word = -1;

    // memory model: one-cycle response after an accepted request
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr          <= 8'h5A;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= 32'd0;
            mem_rsp_err   <= 1'b0;
        end else begin
            lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= mem[mem_req_addr[9:2]];
            mem_rsp_err   <= mem_req_valid && mem_req_ready && (int'(mem_req_addr[9:2]) == err_word);
        end
    end

    assign mem_req_ready = !bp_en || lfsr[0] || lfsr[3];
    assign out_ready     = !bp_en || lfsr[1] || lfsr[6];

    logic [31:0] cap_data  [CAP_MAX];
    logic [2:0]  cap_bytes [CAP_MAX];
    int cap_n = 0, req_n = 0, done_n = 0, err_n = 0;
    int done_cyc = 0, last_beat_cyc = 0, cyc = 0;
    int attr_bad = 0, req_after_err = 0, done_busy_bad = 0;
    bit err_seen = 1'b0;

    logic [31:0] exp_data  [CAP_MAX];
    logic [2:0]  exp_bytes [CAP_MAX];
    int exp_n = 0, exp_req = 0;
    logic [2:0] exp_attr = 3'd0;

    // observation away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (cap_n < CAP_MAX) begin
                    cap_data[cap_n]  = out_data;
                    cap_bytes[cap_n] = out_bytes;
                end
                cap_n++;
                last_beat_cyc = cyc;
            end
            if (mem_req_valid && mem_req_ready) begin
                req_n++;
                if (mem_req_attr !== exp_attr) attr_bad++;
                if (err_seen) req_after_err++;
            end
            if (src_done) begin
                done_n++;
                done_cyc = cyc;
                if (busy) done_busy_bad++;
            end
            if (rd_err) begin
                err_n++;
                err_seen = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic clear_run();
        @(posedge clk);
        cap_n = 0; req_n = 0; done_n = 0; err_n = 0;
        attr_bad = 0; req_after_err = 0; done_busy_bad = 0;
        err_seen = 1'b0;
    endtask

    task automatic clear_exp();
        exp_n = 0;
        exp_req = 0;
    endtask

    task automatic add_seg(input int a, input int len);
        for (int i = 0; i * 4 < len; i++) begin
            exp_data[exp_n]  = mem[(a >> 2) + i];
            exp_bytes[exp_n] = (len - 4 * i >= 4) ? 3'd4 : 3'(len - 4 * i);
            exp_n++;
            exp_req++;
        end
    endtask

    task automatic model_list(input int head);
        int p = head;
        for (int k = 0; k < 16; k++) begin
            exp_req += 4;
            add_seg(int'(mem[(p >> 2)]), int'(mem[(p >> 2) + 1]));
            if (mem[(p >> 2) + 3][31]) break;
            p = int'(mem[(p >> 2) + 2]);
        end
    endtask

    task automatic put_desc(input int at, input int src, input int len, input int nxt, input bit last);
        mem[(at >> 2)]     = 32'(src);
        mem[(at >> 2) + 1] = 32'(len);
        mem[(at >> 2) + 2] = 32'(nxt);
        mem[(at >> 2) + 3] = last ? 32'h8000_0000 : 32'h0000_0011;
    endtask

    task automatic wait_end();
        int waitc = 0;
        while (done_n + err_n == 0 && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        if (waitc >= 3000) chk(1'b0, "R6 transfer end watchdog", 32'(waitc), 32'd3000);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_stream(input string rq);
        int bad = -1;
        chk(cap_n == exp_n, {rq, " output word count"}, 32'(cap_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && (cap_data[i] !== exp_data[i] || cap_bytes[i] !== exp_bytes[i])) bad = i;
        if (bad >= 0)
            chk(1'b0, {rq, " output word content"}, {cap_data[bad][28:0], cap_bytes[bad]},
                {exp_data[bad][28:0], exp_bytes[bad]});
        else
            chk(1'b1, {rq, " output word content"}, 32'd0, 32'd0);
        chk(req_n == exp_req, {rq, " read request count"}, 32'(req_n), 32'(exp_req));
        chk(attr_bad == 0, "R9 attribute on every request", 32'(attr_bad), 32'd0);
    endtask

    task automatic check_done(input bit timing);
        chk(done_n == 1 && err_n == 0, "R6 exactly one done pulse", 32'(done_n), 32'd1);
        chk(!busy && done_busy_bad == 0, "R6 idle at and after done", {31'd0, busy}, 32'd0);
        if (timing)
            chk(done_cyc == last_beat_cyc + 1, "R6 done one cycle after last word",
                32'(done_cyc - last_beat_cyc), 32'd1);
    endtask

    task automatic check_abort();
        chk(err_n == 1, "R7 one error pulse", 32'(err_n), 32'd1);
        chk(done_n == 0, "R7 no done pulse on abort", 32'(done_n), 32'd0);
        chk(!busy, "R7 idle after abort", {31'd0, busy}, 32'd0);
        chk(req_after_err == 0, "R7 no requests after abort", 32'(req_after_err), 32'd0);
    endtask

    task automatic run_list(input int head, input logic [2:0] at, input string rq, input bit timing);
        clear_exp();
        model_list(head);
        exp_attr = at;
        cfg_write(2'd3, 32'(head));
        clear_run();
        cfg_write(2'd0, EN_BIT | LIST_BIT | {1'b0, at, 28'd0});
        wait_end();
        check_stream(rq);
        check_done(timing);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 global watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            logic [7:0] b;
            b = 8'(i);
            mem[i] = {b ^ 8'hA5, b, 8'h3C, ~b};
        end
        put_desc(32'h00, 32'h200, 9, 32'h40, 1'b1);
        put_desc(32'h40, 32'h300, 4, 32'h00, 1'b1);
        put_desc(32'h10, 32'h180, 5, 32'h20, 1'b0);
        put_desc(32'h20, 32'h1C0, 0, 32'h30, 1'b0);
        put_desc(32'h30, 32'h240, 8, 32'h40, 1'b1);
        put_desc(32'h50, 32'h280, 6, 32'h90, 1'b0);
        put_desc(32'h90, 32'h2C0, 3, 32'hA0, 1'b0);
        put_desc(32'hA0, 32'h2E0, 0, 32'h00, 1'b1);
        put_desc(32'hB0, 32'h300, 0, 32'h00, 1'b1);

        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy low in reset", {31'd0, busy}, 32'd0);
        chk(!mem_req_valid && !out_valid, "R1 no request or word in reset",
            {30'd0, mem_req_valid, out_valid}, 32'd0);
        chk(!src_done && !rd_err, "R1 no event in reset", {30'd0, src_done, rd_err}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !out_valid, "R1 quiet after reset",
            {29'd0, busy, mem_req_valid, out_valid}, 32'd0);

        // R11 mode write without enable
        exp_attr = 3'd0;
        cfg_write(2'd3, 32'h10);
        clear_run();
        cfg_write(2'd0, LIST_BIT | 32'h3000_0000);
        repeat (30) @(negedge clk);
        chk(req_n == 0 && !busy && done_n == 0, "R11 no transfer without enable",
            32'(req_n + done_n), 32'd0);

        // R2 R6 R9 R10 single-buffer sweep
        for (int len = 0; len < 14; len++) begin
            logic [2:0] at;
            at    = 3'(len);
            bp_en = len[0];
            clear_exp();
            add_seg(32'h100 + 4 * len, len);
            exp_attr = at;
            cfg_write(2'd1, 32'h100 + 32'(4 * len));
            cfg_write(2'd2, 32'(len));
            clear_run();
            cfg_write(2'd0, EN_BIT | {1'b0, at, 28'd0});
            wait_end();
            check_stream(bp_en ? "R10 R2 single buffer" : "R2 single buffer");
            check_done(len > 0);
        end

        // R3 R4 list walks
        bp_en = 1'b0;
        run_list(32'h00, 3'd5, "R4 terminate ignores next", 1'b1);
        bp_en = 1'b1;
        run_list(32'h10, 3'd2, "R5 R3 contiguous chain", 1'b1);
        bp_en = 1'b0;
        run_list(32'h50, 3'd7, "R4 R5 jumping chain", 1'b0);
        bp_en = 1'b1;
        run_list(32'hB0, 3'd1, "R5 empty terminating head", 1'b0);
        run_list(32'h50, 3'd6, "R10 R3 chain under backpressure", 1'b0);

        // R7 error on a data word
        bp_en = 1'b0;
        err_word = (32'h108 >> 2);
        clear_exp();
        add_seg(32'h100, 8);
        exp_req = 3;
        exp_attr = 3'd4;
        cfg_write(2'd1, 32'h100);
        cfg_write(2'd2, 32'd16);
        clear_run();
        cfg_write(2'd0, EN_BIT | 32'h4000_0000);
        wait_end();
        check_stream("R7 data read error");
        check_abort();

        // R7 error on a descriptor word
        bp_en = 1'b1;
        err_word = (32'h24 >> 2);
        clear_exp();
        add_seg(32'h180, 5);
        exp_req = 8;
        exp_attr = 3'd3;
        cfg_write(2'd3, 32'h10);
        clear_run();
        cfg_write(2'd0, EN_BIT | LIST_BIT | 32'h3000_0000);
        wait_end();
        check_stream("R7 descriptor read error");
        check_abort();
        err_word = -1;

        // R8 mode write while busy
        bp_en = 1'b1;
        clear_exp();
        add_seg(32'h100, 40);
        exp_attr = 3'd5;
        cfg_write(2'd1, 32'h100);
        cfg_write(2'd2, 32'd40);
        clear_run();
        cfg_write(2'd0, EN_BIT | 32'h5000_0000);
        repeat (3) @(negedge clk);
        chk(busy, "R8 busy during transfer", {31'd0, busy}, 32'd1);
        cfg_write(2'd1, 32'h300);
        cfg_write(2'd0, EN_BIT | LIST_BIT | 32'h2000_0000);
        wait_end();
        repeat (30) @(negedge clk);
        check_stream("R8 mode write while busy");
        check_done(1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule